// File: doc/BRIEF.md
# Transmit FIFO with Trigger-Level Empty Flag

This block is the byte queue on the transmit side of a serial port. A host pushes bytes through a write strobe. A downstream shift register takes them in order through a valid/ready pop interface. The block tracks how many bytes it holds and shows that number in the upper byte of a 16-bit count word.

A "transmit data empty" status flag tells the host when it may refill the queue. The flag sets whenever the occupancy that results from a cycle is at or below a threshold. A 2-bit trigger field picks that threshold as a fraction of the depth. After the flag sets, the host can write as many bytes as there are free slots and lose none of them.

Clearing the flag is a two-step handshake: first a status read that sees the flag at 1, then a write of 0. The clear holds only if occupancy is above the threshold. If occupancy is still at or below the threshold, the flag is 1 again on the following cycle.

Top module: `tfifo_trig`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the count is 0, `txe_flag` is 1 and `pop_valid` is 0.
- R2: A write accepted while the queue is not full and no pop occurs raises the count by one. Bytes leave on `pop_data` in the order they were written.
- R3: A write while the count equals DEPTH (16) is dropped: the count stays at DEPTH and that byte never appears at the output.
- R4: In a cycle with an accepted write and a pop (`pop_valid` and `pop_ready` both 1) while not full, the count is unchanged.
- R5: `cnt_reg[15:8]` holds the current count and `cnt_reg[7:0]` is always 0.
- R6: The trigger field sets the threshold: `trig_sel` 0 gives 8, 1 gives 4, 2 gives 2 and 3 gives 1 (DEPTH shifted right by `trig_sel`+1). After any cycle whose resulting count is at or below the threshold, `txe_flag` is 1.
- R7: The flag clears on a clear write (`clr_wr`=1, `clr_val`=0). This needs a status read (`stat_rd`=1) that saw `txe_flag`=1 in an earlier cycle, with no clear write since, and a resulting count above the threshold. Once set, the flag otherwise stays 1, even when the count rises above the threshold.
- R8: A valid clear write made while the resulting count is at or below the threshold leaves `txe_flag` at 1 on the next cycle.
- R9: A clear write with no preceding read-as-1 is ignored: `txe_flag` stays 1. A write with `clr_val`=1 never changes the flag.
- R10: `pop_valid` is 1 exactly when the count is nonzero. A byte is removed only in a cycle with `pop_valid` and `pop_ready` both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host push strobe |
| wr_data | input | 8 | Byte to push |
| pop_valid | output | 1 | Queue holds a byte for the shifter |
| pop_data | output | 8 | Oldest byte in the queue |
| pop_ready | input | 1 | Shifter takes the byte this cycle |
| trig_sel | input | 2 | Trigger threshold select |
| stat_rd | input | 1 | Host status read strobe (arms the clear) |
| clr_wr | input | 1 | Host status write strobe |
| clr_val | input | 1 | Value written to the flag (0 clears) |
| txe_flag | output | 1 | Transmit data empty flag |
| cnt_reg | output | 16 | Count word, occupancy in bits 15:8 |

## Verification
The bound checker watches these on every cycle: that the count never exceeds the depth, that `pop_valid` follows a nonzero count, the push and push-plus-pop count steps, and that the flag is high whenever the count is at or below the threshold selected in the previous cycle. The clear handshake depends on history the ports do not show: a read-as-1 several cycles earlier, and no clear write in between. Byte order through the queue, and the dropping of writes to a full queue, also depend on that kind of history. Those behaviours are shown only by the bench's scenarios and its reference model.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;

    typedef enum logic [1:0] {
        TRIG_HALF      = 2'd0,
        TRIG_QUARTER   = 2'd1,
        TRIG_EIGHTH    = 2'd2,
        TRIG_SIXTEENTH = 2'd3
    } trig_sel_e;

    // Threshold is the depth divided by 2, 4, 8 or 16.
    function automatic int unsigned trig_thresh(input logic [1:0] sel,
                                                input int unsigned depth);
        int unsigned sh;
        sh = 32'(sel) + 32'd1;
        return depth >> sh;
    endfunction

endpackage

// File: rtl/tfifo_store.sv
module tfifo_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_ready,
    output logic          pop_valid,
    output logic [DW-1:0] pop_data,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_next
);

    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [PW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } store_st_t;

    store_st_t     st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic          push_acc;
    logic          pop_acc;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d     = st_q;
        push_acc = push_req && (st_q.cnt != CW'(DEPTH));
        pop_acc  = pop_ready && (st_q.cnt != '0);
        if (push_acc) st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
        if (pop_acc)  st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
        case ({push_acc, pop_acc})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_acc) mem_q[st_q.wr_ptr] <= push_data;
    end

    assign pop_valid = (st_q.cnt != '0);
    assign pop_data  = mem_q[st_q.rd_ptr];
    assign cnt       = st_q.cnt;
    assign cnt_next  = st_d.cnt;

endmodule

// File: rtl/tfifo_flag.sv
module tfifo_flag
    import tfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] cnt_next,
    input  logic          stat_rd,
    input  logic          clr_wr,
    input  logic          clr_val,
    output logic          flag
);

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;

    flag_st_t      st_d, st_q;
    logic [CW-1:0] thr;
    logic          at_or_below;
    logic          clr_ok;

    always_comb begin
        thr         = CW'(trig_thresh(trig_sel, DEPTH));
        at_or_below = (cnt_next <= thr);
        clr_ok      = clr_wr && !clr_val && st_q.armed;
        st_d        = st_q;
        // A level condition wins over a clear in the same cycle.
        st_d.flag   = (clr_ok ? 1'b0 : st_q.flag) | at_or_below;
        if (clr_wr)                    st_d.armed = 1'b0;
        else if (stat_rd && st_q.flag) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{flag: 1'b1, armed: 1'b0};
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/tfifo_trig.sv
module tfifo_trig #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          pop_valid,
    output logic [DW-1:0] pop_data,
    input  logic          pop_ready,
    input  logic [1:0]    trig_sel,
    input  logic          stat_rd,
    input  logic          clr_wr,
    input  logic          clr_val,
    output logic          txe_flag,
    output logic [15:0]   cnt_reg
);

    // The count sits in an 8-bit field, so DEPTH must not exceed 255.
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_next;

    tfifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (wr_en),
        .push_data (wr_data),
        .pop_ready (pop_ready),
        .pop_valid (pop_valid),
        .pop_data  (pop_data),
        .cnt       (cnt),
        .cnt_next  (cnt_next)
    );

    tfifo_flag #(.DEPTH(DEPTH)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_sel (trig_sel),
        .cnt_next (cnt_next),
        .stat_rd  (stat_rd),
        .clr_wr   (clr_wr),
        .clr_val  (clr_val),
        .flag     (txe_flag)
    );

    assign cnt_reg = {8'(cnt), 8'h00};

endmodule

// File: rtl/tfifo_trig_chk.sv
module tfifo_trig_chk
    import tfifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        pop_valid,
    input logic        pop_ready,
    input logic [1:0]  trig_sel,
    input logic        txe_flag,
    input logic [15:0] cnt_reg
);

    logic [7:0] cnt;
    assign cnt = cnt_reg[15:8];

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt) <= DEPTH);

    // R10
    pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid == (cnt != 8'd0));

    // R2
    push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(pop_valid && pop_ready) && 32'(cnt) != DEPTH)
        |=> (cnt == $past(cnt) + 8'd1));

    // R4
    push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pop_valid && pop_ready && 32'(cnt) != DEPTH)
        |=> (cnt == $past(cnt)));

    // R6
    flag_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cnt) <= trig_thresh($past(trig_sel), DEPTH)) |-> txe_flag);

endmodule

bind tfifo_trig tfifo_trig_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .pop_valid (pop_valid),
    .pop_ready (pop_ready),
    .trig_sel  (trig_sel),
    .txe_flag  (txe_flag),
    .cnt_reg   (cnt_reg)
);

// File: tb/tfifo_trig_tb.sv
`timescale 1ns/100ps
module tfifo_trig_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        pop_valid;
    logic [7:0]  pop_data;
    logic        pop_ready = 1'b0;
    logic [1:0]  trig_sel = 2'd0;
    logic        stat_rd = 1'b0;
    logic        clr_wr = 1'b0;
    logic        clr_val = 1'b0;
    logic        txe_flag;
    logic [15:0] cnt_reg;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] sb_q[$];
    bit  pend = 0;
    bit  m_flag = 1;
    bit  m_arm = 0;
    bit  done = 0;
    logic [7:0] nxt = 8'h10;

    always #2.5 clk = ~clk;

    tfifo_trig #(.DEPTH(DEPTH), .DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pop_valid(pop_valid), .pop_data(pop_data), .pop_ready(pop_ready),
        .trig_sel(trig_sel), .stat_rd(stat_rd), .clr_wr(clr_wr),
        .clr_val(clr_val), .txe_flag(txe_flag), .cnt_reg(cnt_reg)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int thr_of(input logic [1:0] s);
        return DEPTH >> (int'(s) + 1);
    endfunction

    // Driver: applies one cycle of stimulus and queues bytes the design must accept.
    task automatic drive(input bit w, input bit rdy, input bit sr,
                         input bit cw, input bit cv);
        @(posedge clk); #1;
        wr_en = w; wr_data = nxt; pop_ready = rdy;
        stat_rd = sr; clr_wr = cw; clr_val = cv;
        pend = 0;
        if (w && sb_q.size() < DEPTH) begin
            sb_q.push_back(nxt);
            pend = 1;
        end
        if (w) nxt = nxt + 8'd7;
    endtask

    task automatic idle(); drive(0, 0, 0, 0, 0); endtask

    // Monitor: compares outputs with the model, pops the scoreboard, advances the flag model.
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 count in reset", int'(cnt_reg[15:8]), 0);
            chk("R1 flag in reset", int'(txe_flag), 1);
            chk("R1 valid in reset", int'(pop_valid), 0);
            sb_q.delete(); m_flag = 1; m_arm = 0; pend = 0;
        end else if (!done) begin
            int pre;
            int post;
            bit clr_ok;
            bit old_flag;
            pre = sb_q.size() - int'(pend);
            chk("R2/R3 count", int'(cnt_reg[15:8]), pre);
            chk("R5 low byte", int'(cnt_reg[7:0]), 0);
            chk("R10 valid", int'(pop_valid), int'(pre != 0));
            chk("R6/R7/R8/R9 flag", int'(txe_flag), int'(m_flag));
            if (pop_valid && pop_ready) begin
                if (sb_q.size() == 0) chk("R10 pop when empty", 1, 0);
                else begin
                    chk("R2 order", int'(pop_data), int'(sb_q[0]));
                    void'(sb_q.pop_front());
                end
            end
            post = sb_q.size();
            old_flag = m_flag;
            clr_ok = clr_wr && !clr_val && m_arm;
            m_flag = (clr_ok ? 1'b0 : m_flag) | (post <= thr_of(trig_sel));
            if (clr_wr) m_arm = 0;
            else if (stat_rd && old_flag) m_arm = 1;
            pend = 0;
        end
    end

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        done = 1;
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count after reset", int'(cnt_reg[15:8]), 0);
        chk("R1 flag after reset", int'(txe_flag), 1);

        // Fill to 5 with threshold 8.
        trig_sel = 2'd0;
        repeat (5) drive(1, 0, 0, 0, 0);
        idle();
        @(negedge clk) chk("R2 count after five writes", int'(cnt_reg[15:8]), 5);
        // Clear while at or below threshold: flag returns.
        drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0);
        idle();
        @(negedge clk) chk("R8 flag re-set", int'(txe_flag), 1);

        // Rise to 12: flag stays set, unarmed clear ignored.
        repeat (7) drive(1, 0, 0, 0, 0);
        idle();
        @(negedge clk) chk("R7 flag sticky above threshold", int'(txe_flag), 1);
        drive(0, 0, 0, 1, 0);
        idle();
        @(negedge clk) chk("R9 unarmed clear ignored", int'(txe_flag), 1);
        drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 1);
        idle();
        @(negedge clk) chk("R9 write of one ignored", int'(txe_flag), 1);
        drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0);
        idle();
        @(negedge clk) chk("R7 flag cleared", int'(txe_flag), 0);
        chk("R5 count word", int'(cnt_reg), 12 << 8);

        // Overfill: last writes dropped.
        repeat (6) drive(1, 0, 0, 0, 0);
        idle();
        @(negedge clk) chk("R3 saturated count", int'(cnt_reg[15:8]), DEPTH);

        // Pop to 14, then push and pop together.
        repeat (2) drive(0, 1, 0, 0, 0);
        repeat (3) drive(1, 1, 0, 0, 0);
        idle();
        @(negedge clk) chk("R4 count held", int'(cnt_reg[15:8]), 14);

        // Drain to 8: flag rises at threshold 8.
        repeat (6) drive(0, 1, 0, 0, 0);
        idle();
        @(negedge clk) chk("R6 flag at threshold 8", int'(txe_flag), 1);

        // Threshold 1: clear at 8, drain to 1.
        trig_sel = 2'd3;
        drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0);
        idle();
        @(negedge clk) chk("R7 cleared at threshold 1", int'(txe_flag), 0);
        repeat (7) drive(0, 1, 0, 0, 0);
        idle();
        @(negedge clk) chk("R6 flag at threshold 1", int'(txe_flag), 1);

        // Threshold 4 and 2 patterns.
        trig_sel = 2'd1;
        repeat (5) drive(1, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0);
        drive(0, 0, 0, 1, 0);
        idle();
        @(negedge clk) chk("R7 cleared at count 6 threshold 4", int'(txe_flag), 0);
        trig_sel = 2'd2;
        repeat (4) drive(0, 1, 0, 0, 0);
        idle();
        @(negedge clk) chk("R6 flag at threshold 2", int'(txe_flag), 1);

        // Drain completely.
        repeat (4) drive(0, 1, 0, 0, 0);
        idle();
        @(negedge clk) chk("R10 valid low when empty", int'(pop_valid), 0);
        repeat (2) idle();

        @(negedge clk);
        done = 1;
        report();
    end

endmodule